// File: doc/BRIEF.md
# Multicart ROM Page Selector

This block decides which 8 KB page of a large cartridge ROM the CPU sees in its 8 KB cartridge window (CPU addresses 0x6000 to 0x7FFF). It watches the 16-bit CPU address bus and its read and write strobes. It drives the upper physical ROM address lines and a ROM chip-enable. A page is chosen by the address of a write into the window. The data of that write plays no part.

Several multi-page games can share one ROM. A menu program writes a control word once before it starts a game. The word sets a page base, the game's size in pages and whether the game expects the inverted page order. It can also set a lock bit. The game then pages through what it takes to be pages 0 to N-1. The block adds the base, so the game runs unmodified from any position in the ROM. Once the lock bit is set, the game cannot disturb the control word again until reset.

Top module: `mcart_bank_ctrl`

## Requirements
- R1: `rom_ce` is high exactly while `cpu_rd` is high and `cpu_addr` lies in 0x6000..0x7FFF. It is low for a read outside the window and when `cpu_rd` is low.
- R2: In non-inverted mode, a write to 0x6000 + 2n selects relative page n. Address bit 0 and the write data are ignored. The new page is visible on `rom_bank` after the clock edge that samples the write.
- R3: In inverted mode with N pages, a write to 0x6000 + 2n selects relative page N-1-n. With N = 2, 0x6000 selects page 1 and 0x6002 selects page 0.
- R4: The page index n is reduced modulo the game size N before the page order is applied.
- R5: `rom_bank` equals the base plus the relative page, taken modulo 64.
- R6: A read, or a write outside the window and away from the control address, leaves `rom_bank` unchanged.
- R7: A write to the control address 0x5FFE loads the control word from `cpu_wdata`. The fields are: base in bits [5:0], log2 of the game size in bits [8:6] (values above 6 mean 64 pages), inverted mode in bit 9 and lock in bit 15.
- R8: After the lock bit has been written as 1, later control writes are ignored until reset. Page writes into the window keep working.
- R9: After reset the base is 0, the size is 64 pages, the mode is non-inverted and the lock is clear. With the default parameters `rom_bank` is 0.
- R10: A control write leaves the latched page index in place. `rom_bank` is recomputed from that index under the new size, mode and base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 16 | CPU write data; used only by control writes |
| cpu_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| cpu_rd | input | 1 | Read strobe |
| rom_bank | output | 6 | Physical 8 KB page number (upper ROM address lines) |
| rom_ce | output | 1 | ROM chip-enable for reads inside the window |

## Verification
The hardest case to reach is how a control write interacts with a page index that was latched earlier. Examples are a base near 63 that wraps, a size change that masks off high index bits, and a mode flip that reorders the page already selected. A vector table reaches these cases by interleaving control writes with page writes. Each step checks the output against a value worked out by hand from the requirements. A directed sequence then sets the lock and tries to overwrite the base. It confirms that page writes still work, and that a reset clears the lock.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
   localparam int SIZE_FW = 3;

   typedef struct packed {
      logic               lock;
      logic               invert;
      logic [SIZE_FW-1:0] size_log2;
   } mode_t;
endpackage

// File: rtl/mcb_decode.sv
module mcb_decode #(
   parameter int          BANK_W    = 6,
   parameter logic [15:0] WIN_BASE  = 16'h6000,
   parameter logic [15:0] CTRL_ADDR = 16'h5FFE
) (
   input  logic [15:0]       addr,
   input  logic              wr,
   input  logic              rd,
   output logic              win_rd,
   output logic              page_wr,
   output logic              ctrl_wr,
   output logic [BANK_W-1:0] page_idx
);
   localparam int WIN_BITS = 13;

   initial begin
      if (WIN_BASE[WIN_BITS-1:0] != '0)
         $error("window base must be 8 KB aligned");
      if (CTRL_ADDR[15:WIN_BITS] == WIN_BASE[15:WIN_BITS])
         $error("control address must lie outside the window");
      if (BANK_W < 1 || BANK_W > WIN_BITS - 1)
         $error("BANK_W out of range");
   end

   logic in_win;

   always_comb begin
      in_win   = (addr[15:WIN_BITS] == WIN_BASE[15:WIN_BITS]);
      win_rd   = in_win && rd;
      page_wr  = in_win && wr;
      ctrl_wr  = wr && (addr[15:1] == CTRL_ADDR[15:1]);
      page_idx = addr[BANK_W:1];
   end
endmodule

// File: rtl/mcb_ctrl.sv
module mcb_ctrl
   import mcb_pkg::*;
#(
   parameter int          BANK_W     = 6,
   parameter logic        RST_INVERT = 1'b0,
   parameter int          RST_SIZE   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [15:0]       wdata,
   output logic [BANK_W-1:0] base_q,
   output mode_t             mode_q
);
   localparam int LOCK_BIT = 15;
   localparam int INV_BIT  = 9;
   localparam int SIZE_LSB = 6;

   initial begin
      if (RST_SIZE < 0 || RST_SIZE > BANK_W)
         $error("RST_SIZE out of range");
      if (BANK_W > SIZE_LSB)
         $error("base field is limited to 6 bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q           <= '0;
         mode_q.lock      <= 1'b0;
         mode_q.invert    <= RST_INVERT;
         mode_q.size_log2 <= SIZE_FW'(RST_SIZE);
      end else if (ctrl_wr && !mode_q.lock) begin
         base_q           <= wdata[BANK_W-1:0];
         mode_q.lock      <= wdata[LOCK_BIT];
         mode_q.invert    <= wdata[INV_BIT];
         mode_q.size_log2 <= wdata[SIZE_LSB +: SIZE_FW];
      end
   end

   // R8: once locked, the control word stays put until reset
   a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q.lock |=> mode_q.lock && $stable(base_q) && $stable(mode_q));
endmodule

// File: rtl/mcb_latch.sv
module mcb_latch #(
   parameter int   BANK_W   = 6,
   parameter logic RST_FILL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_wr,
   input  logic [BANK_W-1:0] page_idx,
   output logic [BANK_W-1:0] idx_q
);
   logic [BANK_W-1:0] rst_val;

   generate
      if (RST_FILL) begin : g_rst_ones
         assign rst_val = '1;
      end else begin : g_rst_zero
         assign rst_val = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       idx_q <= rst_val;
      else if (page_wr) idx_q <= page_idx;
   end

   // R6: without a window write the index does not move
   a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !page_wr |=> $stable(idx_q));
   // R2: a window write captures the page index
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      page_wr |=> idx_q == $past(page_idx));
endmodule

// File: rtl/mcb_map.sv
module mcb_map
   import mcb_pkg::*;
#(
   parameter int BANK_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] idx_q,
   input  logic [BANK_W-1:0] base_q,
   input  mode_t             mode_q,
   output logic [BANK_W-1:0] phys
);
   logic [SIZE_FW-1:0] size_eff;
   logic [BANK_W-1:0]  mask;
   logic [BANK_W-1:0]  rel;

   always_comb begin
      if (int'(mode_q.size_log2) > BANK_W) size_eff = SIZE_FW'(BANK_W);
      else                                 size_eff = mode_q.size_log2;
      mask = ~({BANK_W{1'b1}} << size_eff);
      // inverted order: N-1-n equals mask XOR n for N a power of two
      rel  = mode_q.invert ? (mask ^ (idx_q & mask)) : (idx_q & mask);
      phys = base_q + rel;
   end

   // R4: the relative page never leaves the game's size
   a_r4_rel_in_game: assert property (@(posedge clk) disable iff (!rst_n)
      (rel & ~mask) == '0);
   // R5: with a zero base the physical page is the relative page
   a_r5_base_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (base_q == '0) |-> (phys == rel));
endmodule

// File: rtl/mcart_bank_ctrl.sv
module mcart_bank_ctrl
   import mcb_pkg::*;
#(
   parameter int          BANK_W     = 6,
   parameter logic [15:0] WIN_BASE   = 16'h6000,
   parameter logic [15:0] CTRL_ADDR  = 16'h5FFE,
   parameter logic        RST_INVERT = 1'b0,
   parameter int          RST_SIZE   = 6,
   parameter logic        RST_LAST   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [15:0]       cpu_wdata,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   output logic [BANK_W-1:0] rom_bank,
   output logic              rom_ce
);
   // an all-ones index is the last page in normal order, the first in inverted
   localparam logic RST_FILL = RST_LAST ^ RST_INVERT;

   logic              page_wr, ctrl_wr, win_rd;
   logic [BANK_W-1:0] page_idx, idx_q, base_q;
   mode_t             mode_q;

   mcb_decode #(.BANK_W(BANK_W), .WIN_BASE(WIN_BASE), .CTRL_ADDR(CTRL_ADDR)) u_dec (
      .addr(cpu_addr), .wr(cpu_wr), .rd(cpu_rd),
      .win_rd(win_rd), .page_wr(page_wr), .ctrl_wr(ctrl_wr), .page_idx(page_idx)
   );

   mcb_ctrl #(.BANK_W(BANK_W), .RST_INVERT(RST_INVERT), .RST_SIZE(RST_SIZE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(cpu_wdata),
      .base_q(base_q), .mode_q(mode_q)
   );

   mcb_latch #(.BANK_W(BANK_W), .RST_FILL(RST_FILL)) u_latch (
      .clk(clk), .rst_n(rst_n), .page_wr(page_wr), .page_idx(page_idx), .idx_q(idx_q)
   );

   mcb_map #(.BANK_W(BANK_W)) u_map (
      .clk(clk), .rst_n(rst_n), .idx_q(idx_q), .base_q(base_q), .mode_q(mode_q),
      .phys(rom_bank)
   );

   assign rom_ce = win_rd;

   // R6: a cycle with no write leaves the output page unchanged
   a_r6_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_wr |=> $stable(rom_bank));
   // R1: the chip-enable is never raised without a read strobe
   a_r1_ce_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      rom_ce |-> cpu_rd);
endmodule

// File: tb/test_mcart_bank_ctrl.sv
module test_mcart_bank_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [15:0] cpu_wdata = 16'h0000;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [5:0]  rom_bank;
   logic        rom_ce;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mcart_bank_ctrl i_mcart_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_bank(rom_bank), .rom_ce(rom_ce)
   );

   // {req, addr, data, expected bank}
   localparam int NV = 17;
   localparam logic [47:0] VEC [NV] = '{
      {8'd2,  16'h6000, 16'h0000, 8'd0},   // R2
      {8'd2,  16'h600A, 16'hFFFF, 8'd5},   // R2 data ignored
      {8'd2,  16'h600B, 16'h1234, 8'd5},   // R2 bit 0 ignored
      {8'd2,  16'h607E, 16'h0000, 8'd63},  // R2 top index
      {8'd10, 16'h5FFE, 16'h0088, 8'd11},  // R10 base 8, 4 pages, index 63 -> 3
      {8'd5,  16'h6002, 16'h0000, 8'd9},   // R5
      {8'd5,  16'h6006, 16'h0000, 8'd11},  // R5
      {8'd4,  16'h600C, 16'h0000, 8'd10},  // R4 index 6 mod 4 = 2
      {8'd10, 16'h5FFE, 16'h0288, 8'd9},   // R10 inverted reinterprets index 2
      {8'd3,  16'h6000, 16'h0000, 8'd11},  // R3
      {8'd3,  16'h6002, 16'h0000, 8'd10},  // R3
      {8'd3,  16'h6006, 16'h0000, 8'd8},   // R3
      {8'd5,  16'h5FFE, 16'h00BE, 8'd1},   // R5 base 62 + 3 wraps
      {8'd7,  16'h5FFE, 16'h01C0, 8'd3},   // R7 size field 7 -> 64 pages
      {8'd7,  16'h6046, 16'h0000, 8'd35},  // R7 full index range
      {8'd7,  16'h5FFE, 16'h0244, 8'd4},   // R7 base 4, 2 pages, inverted
      {8'd3,  16'h6000, 16'h0000, 8'd5}    // R3 16 KB: 0x6000 -> second page
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0; cpu_addr = 16'h0000;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      do_reset();
      chk("R9 reset bank", 8'(rom_bank), 8'd0);
      chk("R9 reset ce", 8'(rom_ce), 8'd0);

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][39:24], VEC[i][23:8]);
         chk($sformatf("R%0d vector %0d", VEC[i][47:40], i), 8'(rom_bank), VEC[i][7:0]);
      end

      // R1 chip-enable
      @(negedge clk); cpu_addr = 16'h7FFE; cpu_rd = 1'b1; #1;
      chk("R1 ce in window", 8'(rom_ce), 8'd1);
      cpu_addr = 16'h8000; #1;
      chk("R1 ce outside", 8'(rom_ce), 8'd0);
      cpu_addr = 16'h6000; cpu_rd = 1'b0; #1;
      chk("R1 ce no read", 8'(rom_ce), 8'd0);

      // R6 reads and outside writes leave the page
      @(negedge clk); cpu_addr = 16'h6002; cpu_rd = 1'b1;
      repeat (3) @(negedge clk);
      cpu_rd = 1'b0;
      chk("R6 read no change", 8'(rom_bank), 8'd5);
      wr(16'h4002, 16'h00FF);
      chk("R6 outside write", 8'(rom_bank), 8'd5);

      // R8 lock
      wr(16'h5FFE, 16'h8182);          // base 2, 64 pages, lock; index 0
      chk("R8 locked write applied", 8'(rom_bank), 8'd2);
      wr(16'h5FFE, 16'h000A);
      chk("R8 later ctrl ignored", 8'(rom_bank), 8'd2);
      wr(16'h6004, 16'h0000);
      chk("R8 page write works", 8'(rom_bank), 8'd4);

      do_reset();
      chk("R9 reset clears base", 8'(rom_bank), 8'd0);
      wr(16'h5FFE, 16'h0185);
      chk("R9 lock cleared by reset", 8'(rom_bank), 8'd5);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule